// File: doc/BRIEF.md
# Parabolic-Segment Sine Interpolator

This block turns an unsigned phase word into a signed sine sample over a full turn. It holds no large table. Instead it keeps a short list of parabolic pieces. Each piece is described by its two end values and one bend term. The result is formed from the position inside the selected piece as y0 + (y1 − y0)·t + c·t·(1 − t).

The coefficients are computed when the design is elaborated. The simplest fit is used, in which both ends and the midpoint of every piece land exactly on the sine. A mode input chooses between two layouts:

- **Full-turn:** the 32 pieces cover the whole circle.
- **Quarter-turn:** the same number of pieces cover only the first 90°, the phase is folded by quadrant, and the sign is restored at the end.

Samples enter with a valid strobe, one per clock if desired, and leave a fixed number of cycles later with their own valid strobe. The evaluation uses two registered multiply stages.

Top module: `parabolic_sine`

## Requirements
- R1: While reset is asserted and right after it, outValid is 0 and outSample is 0.
- R2: A sample taken with inValid high at clock edge n gives outValid high after edge n+2, so the result is seen three cycles after it was presented. Back-to-back inputs produce back-to-back outputs in the same order.
- R3: In full-turn mode, the top SEG_BITS phase bits (phase[15:11] by default) select one of 32 pieces and the lower bits form t. At every piece start (phase = k·2048), outSample equals AMP·sin(2π·phase/65536) within 1 LSB, where AMP = 32767.
- R4: In full-turn mode, at every piece midpoint (phase = k·2048 + 1024), outSample equals AMP·sin(2π·phase/65536) within 1 LSB.
- R5: In full-turn mode, for any phase, |outSample − AMP·sin(2π·phase/65536)| ≤ 0.01·AMP + 1.
- R6: With quarterMode = 1, the sine is still produced over the whole turn, as follows, and the error stays within 0.002·AMP + 1:
  - phase[15:14] is the quadrant;
  - quadrants 1 and 3 mirror the remaining bits;
  - quadrants 2 and 3 negate the result;
  - the pieces span 0°..90°.
- R7: With quarterMode = 1, the quadrant points are exact: phase 0x0000 and phase 0x8000 give 0, phase 0x4000 gives +AMP, and phase 0xC000 gives −AMP.
- R8: quarterMode is captured only together with inValid. Each sample is evaluated in the mode present with it, and changes of quarterMode while inValid is low have no effect on any result.
- R9: outSample changes only when a new result is delivered. While outValid is low it holds the last result.
- R10: outSample never leaves the range −AMP..+AMP. The result is saturated to that range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Phase sample strobe |
| inPhase | input | PHASE_W | Unsigned phase, full scale equals one turn |
| quarterMode | input | 1 | 1 selects quarter-turn pieces with quadrant folding, 0 selects full-turn pieces |
| outValid | output | 1 | Result strobe |
| outSample | output | OUT_W | Signed two's-complement sine sample |

## Verification
Several properties are checked on every cycle by in-line properties:

- the three-cycle valid latency;
- the saturation range of the output;
- the holding of the output between results;
- the sign of folded lower-half results;
- the stage-one registers staying put while no sample arrives, which is what makes a mode change outside a sample harmless.

The bench's scenarios are needed for what the numbers must be: exactness at piece ends, midpoints and quadrant points, the 1 % and 0.2 % error bounds over dense phase sweeps in both modes, and per-sample mode capture. The mode-capture check uses a coarse four-piece instance, where the two modes give clearly different values.

// File: rtl/psine_pkg.sv
package psine_pkg;

  // stage load strobes handed from control to datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageCtrl_t;

  // sin(2*pi*num/den) scaled to amp, rounded; den must divide 2^20
  function automatic longint sinTurn(input longint num, input longint den, input longint amp);
    longint p, q, r, x, x2, term, sum, mag;
    p = (num * 64'sd1048576) / den;
    p = p % 64'sd1048576;
    q = p >>> 18;
    r = p & 64'sd262143;
    if (q == 1 || q == 3) r = 64'sd262144 - r;
    x = (r * 64'sd1686629713) >>> 18;     // radians in Q30
    x2 = (x * x) >>> 30;
    term = x;
    sum = x;
    for (int n = 1; n < 8; n++) begin
      term = -((term * x2) >>> 30) / ((2 * n) * (2 * n + 1));
      sum = sum + term;
    end
    mag = (sum * amp + 64'sd536870912) >>> 30;
    if (mag > amp) mag = amp;
    if (mag < 0) mag = 0;
    return (q >= 2) ? -mag : mag;
  endfunction

endpackage

// File: rtl/psine_rom.sv
module psine_rom #(
  parameter int OUT_W = 16,
  parameter int SEG_BITS = 5
) (
  input  logic                    quarter,
  input  logic [SEG_BITS:0]       seg,
  output logic signed [OUT_W:0]   y0,
  output logic signed [OUT_W:0]   y1,
  output logic signed [OUT_W+1:0] curv
);
  import psine_pkg::*;

  localparam int NSEG = 2 ** SEG_BITS;
  localparam longint AMP = (64'sd1 <<< (OUT_W - 1)) - 1;

  logic signed [OUT_W:0]   endFull [NSEG+1];
  logic signed [OUT_W:0]   endQtr  [NSEG+1];
  logic signed [OUT_W+1:0] curvFull[NSEG];
  logic signed [OUT_W+1:0] curvQtr [NSEG];

  // end values: even half-points of the span
  for (genvar i = 0; i <= NSEG; i++) begin : gEnd
    localparam longint VF = sinTurn(2 * i, 2 * NSEG, AMP);
    localparam longint VQ = sinTurn(2 * i, 8 * NSEG, AMP);
    assign endFull[i] = (OUT_W+1)'(VF);
    assign endQtr[i]  = (OUT_W+1)'(VQ);
  end

  // bend term c = 4*mid - 2*start - 2*end makes the midpoint exact
  for (genvar i = 0; i < NSEG; i++) begin : gCurv
    localparam longint CF = 4 * sinTurn(2 * i + 1, 2 * NSEG, AMP)
                          - 2 * sinTurn(2 * i, 2 * NSEG, AMP)
                          - 2 * sinTurn(2 * i + 2, 2 * NSEG, AMP);
    localparam longint CQ = 4 * sinTurn(2 * i + 1, 8 * NSEG, AMP)
                          - 2 * sinTurn(2 * i, 8 * NSEG, AMP)
                          - 2 * sinTurn(2 * i + 2, 8 * NSEG, AMP);
    assign curvFull[i] = (OUT_W+2)'(CF);
    assign curvQtr[i]  = (OUT_W+2)'(CQ);
  end

  logic                atEnd;
  logic [SEG_BITS:0]   nxt;

  always_comb begin
    atEnd = (seg == (SEG_BITS+1)'(NSEG));
    nxt   = atEnd ? seg : seg + 1'b1;
    y0    = quarter ? endQtr[seg] : endFull[seg];
    y1    = quarter ? endQtr[nxt] : endFull[nxt];
    if (atEnd) curv = '0;
    else       curv = quarter ? curvQtr[seg[SEG_BITS-1:0]] : curvFull[seg[SEG_BITS-1:0]];
  end

endmodule

// File: rtl/psine_ctrl.sv
module psine_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output psine_pkg::stageCtrl_t  ctrl,
  output logic                   outValid
);
  logic v1, v2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      outValid <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      outValid <= v2;
    end
  end

  assign ctrl.ld1 = inValid;
  assign ctrl.ld2 = v1;
  assign ctrl.ld3 = v2;

  // R2: a sample accepted now is delivered three edges later
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

endmodule

// File: rtl/psine_datapath.sv
module psine_datapath #(
  parameter int PHASE_W = 16,
  parameter int OUT_W = 16,
  parameter int SEG_BITS = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  psine_pkg::stageCtrl_t       ctrl,
  input  logic [PHASE_W-1:0]          inPhase,
  input  logic                        quarterMode,
  output logic signed [OUT_W-1:0]     outSample
);
  localparam int F     = PHASE_W - SEG_BITS;   // fraction bits of t
  localparam int QW    = PHASE_W - 2;          // bits below the quadrant
  localparam int W2    = 2 * F;
  localparam int ACC_W = OUT_W + 2 * F + 4;
  localparam logic [W2-1:0] ONE_F = W2'(1) << F;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (W2 - 1);
  localparam logic signed [ACC_W-1:0] AMPV = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [OUT_W-1:0] AMP_OUT = {1'b0, {(OUT_W-1){1'b1}}};

  // stage 0: fold and segment select
  logic [1:0]          quad;
  logic [QW-1:0]       rq;
  logic [QW:0]         rExt;
  logic [SEG_BITS:0]   seg0;
  logic [F-1:0]        t0;
  logic                neg0;

  always_comb begin
    quad = inPhase[PHASE_W-1 -: 2];
    rq   = inPhase[QW-1:0];
    rExt = quad[0] ? (((QW+1)'(1) << QW) - {1'b0, rq}) : {1'b0, rq};
    if (quarterMode) begin
      seg0 = rExt[QW -: SEG_BITS+1];
      t0   = {rExt[QW-SEG_BITS-1:0], 2'b00};
      neg0 = quad[1];
    end else begin
      seg0 = {1'b0, inPhase[PHASE_W-1 -: SEG_BITS]};
      t0   = inPhase[F-1:0];
      neg0 = 1'b0;
    end
  end

  logic signed [OUT_W:0]   romY0, romY1;
  logic signed [OUT_W+1:0] romC;

  psine_rom #(.OUT_W(OUT_W), .SEG_BITS(SEG_BITS)) uRom (
    .quarter(quarterMode), .seg(seg0), .y0(romY0), .y1(romY1), .curv(romC)
  );

  // stage 1: coefficients registered
  logic signed [OUT_W:0]   s1Y0;
  logic signed [OUT_W+1:0] s1D, s1C;
  logic [F-1:0]            s1T;
  logic                    s1Neg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Y0 <= '0; s1D <= '0; s1C <= '0; s1T <= '0; s1Neg <= 1'b0;
    end else if (ctrl.ld1) begin
      s1Y0  <= romY0;
      s1D   <= (OUT_W+2)'(romY1) - (OUT_W+2)'(romY0);
      s1C   <= romC;
      s1T   <= t0;
      s1Neg <= neg0;
    end
  end

  // stage 2: first multiplies, slope term and t*(1-t)
  logic signed [ACC_W-1:0] s2P1;
  logic [W2-1:0]           s2W;
  logic signed [OUT_W:0]   s2Y0;
  logic signed [OUT_W+1:0] s2C;
  logic                    s2Neg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2P1 <= '0; s2W <= '0; s2Y0 <= '0; s2C <= '0; s2Neg <= 1'b0;
    end else if (ctrl.ld2) begin
      s2P1  <= ACC_W'(s1D) * ACC_W'(signed'({1'b0, s1T}));
      s2W   <= W2'(s1T) * (ONE_F - W2'(s1T));
      s2Y0  <= s1Y0;
      s2C   <= s1C;
      s2Neg <= s1Neg;
    end
  end

  // stage 3: bend multiply, sum, round, sign, saturate
  logic signed [ACC_W-1:0] sum, mag, val, sat;

  always_comb begin
    sum = (ACC_W'(s2Y0) <<< W2) + (s2P1 <<< F)
        + ACC_W'(s2C) * ACC_W'(signed'({1'b0, s2W})) + HALF;
    mag = sum >>> W2;
    val = s2Neg ? -mag : mag;
    if (val > AMPV)       sat = AMPV;
    else if (val < -AMPV) sat = -AMPV;
    else                  sat = val;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outSample <= '0;
    else if (ctrl.ld3) outSample <= sat[OUT_W-1:0];
  end

  // R10: output kept inside the symmetric range
  assert_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outSample <= AMP_OUT) && (outSample >= -AMP_OUT));

  // R9: result holds unless a new one is delivered
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.ld3 |=> $stable(outSample));

  // R6: lower-half quadrants give a non-positive sample
  assert_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ld3 && s2Neg) |=> (outSample <= 0));

  // R8: without a sample the captured mode-dependent state is untouched
  assert_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.ld1 |=> ($stable(s1T) && $stable(s1Neg) && $stable(s1C)));

endmodule

// File: rtl/parabolic_sine.sv
module parabolic_sine #(
  parameter int PHASE_W = 16,
  parameter int OUT_W = 16,
  parameter int SEG_BITS = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [PHASE_W-1:0]       inPhase,
  input  logic                     quarterMode,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outSample
);
  psine_pkg::stageCtrl_t ctrl;

  psine_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  psine_datapath #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .SEG_BITS(SEG_BITS)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inPhase(inPhase),
    .quarterMode(quarterMode), .outSample(outSample)
  );

endmodule

// File: tb/parabolic_sine_test.sv
module parabolic_sine_test;
  localparam real AMP = 32767.0;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic quarterMode = 1'b0;
  logic [15:0] inPhase = '0;
  logic outValid;
  logic signed [15:0] outSample;

  logic cInValid = 1'b0;
  logic cMode = 1'b0;
  logic [15:0] cPhase = '0;
  logic cOutValid;
  logic signed [15:0] cOutSample;

  always #10 clk = ~clk;

  parabolic_sine uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPhase(inPhase),
    .quarterMode(quarterMode), .outValid(outValid), .outSample(outSample)
  );

  // coarse four-piece instance: modes give clearly different values
  parabolic_sine #(.SEG_BITS(2)) uutCoarse (
    .clk(clk), .rstN(rstN), .inValid(cInValid), .inPhase(cPhase),
    .quarterMode(cMode), .outValid(cOutValid), .outSample(cOutSample)
  );

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  real curTol = 1.0;
  string curTag = "R3";
  real qIdeal[$];
  real qTol[$];
  string qTag[$];
  bit vh[$];
  logic signed [15:0] lastOut = '0;

  function automatic real ideal(input int ph);
    return AMP * $sin(2.0 * PI * ph / 65536.0);
  endfunction

  task automatic check(input bit ok, input string tag, input real act, input real expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0f expected=%0f", tag, act, expv);
    end
  endtask

  // reference model: record accepted samples
  always @(posedge clk) begin
    if (rstN) begin
      vh.push_back(inValid);
      if (vh.size() > 3) void'(vh.pop_front());
      if (inValid) begin
        qIdeal.push_back(ideal(int'(inPhase)));
        qTol.push_back(curTol);
        qTag.push_back(curTag);
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && running) begin
      bit expV;
      expV = (vh.size() >= 3) ? vh[vh.size()-3] : 1'b0;
      check(outValid == expV, "R2 valid timing", real'(outValid), real'(expV));
      if (outValid && expV && qIdeal.size() > 0) begin
        real id, tl, df;
        string tg;
        id = qIdeal.pop_front();
        tl = qTol.pop_front();
        tg = qTag.pop_front();
        df = real'(outSample) - id;
        if (df < 0.0) df = -df;
        check(df <= tl, tg, real'(outSample), id);
        check(outSample <= 16'sd32767 && outSample >= -16'sd32767, "R10 range",
              real'(outSample), id);
        lastOut = outSample;
      end else if (!outValid) begin
        check(outSample == lastOut, "R9 hold", real'(outSample), real'(lastOut));
      end
    end
  end

  task automatic send(input int ph, input bit q, input real tol, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inPhase = 16'(ph);
    quarterMode = q;
    curTol = tol;
    curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inPhase = 16'(i * 4099);
      quarterMode = ~quarterMode;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    real tolFull;
    real tolQtr;
    tolFull = 0.01 * AMP + 1.0;
    tolQtr = 0.002 * AMP + 1.0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", real'(outValid), 0.0);
    check(outSample == 16'sd0, "R1 reset sample", real'(outSample), 0.0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outSample == 16'sd0, "R1 after release",
          real'(outSample), 0.0);

    // R3: piece starts, back to back (also R2 throughput)
    for (int k = 0; k < 32; k++) send(k * 2048, 1'b0, 1.0, "R3 piece start");
    // R4: piece midpoints
    for (int k = 0; k < 32; k++) send(k * 2048 + 1024, 1'b0, 1.0, "R4 piece midpoint");
    idle(4);

    // R7: quadrant points in quarter mode
    send(16'h0000, 1'b1, 1.0, "R7 quadrant point");
    send(16'h4000, 1'b1, 1.0, "R7 quadrant point");
    send(16'h8000, 1'b1, 1.0, "R7 quadrant point");
    send(16'hC000, 1'b1, 1.0, "R7 quadrant point");
    idle(5);

    // R5: dense full-turn sweep with gaps
    for (int i = 0; i < 2048; i++) begin
      send(i * 32 + (i % 29), 1'b0, tolFull, "R5 full-turn accuracy");
      if (i % 5 == 3) idle(1 + i % 3);
    end
    idle(4);

    // R6: dense quarter-mode sweep, all quadrants
    for (int i = 0; i < 2048; i++) begin
      send(i * 32 + (i % 31), 1'b1, tolQtr, "R6 quarter accuracy");
      if (i % 7 == 2) idle(2);
    end
    // alternating modes back to back
    for (int i = 0; i < 64; i++)
      send(i * 1021 + 7, i[0], (i[0] ? tolQtr : tolFull), "R8 per-sample mode");
    idle(6);

    // R8: coarse instance, quarter sample while mode toggles when idle
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      cInValid = 1'b1; cPhase = 16'h0800 + 16'(r * 16'h4000); cMode = 1'b1;
      @(negedge clk);
      cInValid = 1'b0; cMode = 1'b0; cPhase = 16'h0400;
      @(negedge clk);
      cMode = 1'b1; cPhase = 16'h1234;
      @(negedge clk);
      cMode = 1'b0;
      begin
        real id, df;
        id = ideal(16'h0800 + r * 16'h4000);
        df = real'(cOutSample) - id;
        if (df < 0.0) df = -df;
        check(cOutValid == 1'b1, "R8 coarse valid", real'(cOutValid), 1.0);
        check(df <= 1.0, "R8 mode captured with sample", real'(cOutSample), id);
      end
      @(negedge clk);
      check(cOutValid == 1'b0, "R9 coarse strobe drop", real'(cOutValid), 0.0);
    end

    idle(6);
    running = 1'b0;
    check(qIdeal.size() == 0, "R2 all results delivered", real'(qIdeal.size()), 0.0);
    finishRun();
  end

endmodule